// File: doc/BRIEF.md
# SPI display command engine

This block is the host side of a four-wire serial link to a small display controller. The link carries 8-bit words and has a separate data/command select line. A request gives a command byte, a count and a runtime clock divider. The engine lowers chip select and shifts the command byte out with the select line low. For a write, it then takes parameter bytes one by one on a valid/ready stream and shifts each one out with the select line high. For a read, it keeps the select line low and clocks in the reply from MISO. Each reply byte comes back on a response port as a one-cycle pulse. The serial link runs in mode 0: the clock idles low, MOSI changes while the clock is low, MISO is sampled on the rising edge, and bytes go out most significant bit first.

The engine decides from a fixed opcode list whether a command is a read or a write. It picks the serial half-period for each phase. The command byte and short parameter blocks are held to about 10 MHz. Parameter blocks longer than 64 bytes run at the full rate set by the divider. Reads are held to about 2 MHz, and never to more than half the full rate. Two queries, the identity query (0x04) and the status query (0x09), answer after one dummy clock. For these the engine reads one extra byte and shifts the reply left by one bit.

The control state machine has these states: IDLE, REJECT, CMD, PAR_WAIT, PAR_SHIFT, RD_SHIFT and DONE. Its transitions are:
- IDLE goes to CMD when a valid request is accepted.
- IDLE goes to REJECT when the request is an invalid read. REJECT goes back to IDLE in the next cycle.
- CMD goes to RD_SHIFT after the command byte of a read.
- CMD goes to DONE after the command byte of a write with zero parameters.
- CMD goes to PAR_WAIT after the command byte of a write with parameters.
- PAR_WAIT goes to PAR_SHIFT when a parameter byte arrives.
- PAR_SHIFT goes back to PAR_WAIT while parameters remain, and to DONE after the last one.
- RD_SHIFT repeats for each reply byte and goes to DONE after the last one.
- DONE goes to IDLE.

Top module: `dbi_spi_engine`

## Requirements
- R1: Chip select goes low at the start of the command byte. It stays low, with no release, until the last parameter or reply byte is done, then goes high. `req_ready` is high only when no transaction is in progress.
- R2: The command byte goes out most significant bit first, with D/C low during all eight clocks.
- R3: Parameter bytes are taken only while `par_ready` is high. Each one goes out most significant bit first with D/C high. A write with a count of zero ends after the command byte.
- R4: A command is a read only if its opcode is in this set: 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8. Every other opcode, including the window commands 0x2A and 0x2B and the memory write 0x2C, is a write.
- R5: During a read, D/C stays low and MOSI is driven 0 after the command byte. The engine clocks in `req_len` reply bytes, sampling MISO on each rising SCLK edge, most significant bit first. It returns them in order on `rsp_data`.
- R6: The engine rejects a read with a count of zero, and a 0x04 or 0x09 read with a count other than 3 or 4. A rejected request gives one `err` pulse, and chip select never goes low.
- R7: For 0x04 and 0x09, the engine clocks in `req_len`+1 bytes rx[0..n]. Reply byte i is ((rx[i] << 1) | (rx[i+1] >> 7)) & 0xFF.
- R8: During the reply bytes of a read, the SCLK half-period in system clocks is the larger of ceil(SYS_HZ/4 MHz) and twice the effective divider.
- R9: The command byte and a parameter block of 64 bytes or fewer use a half-period equal to the larger of ceil(SYS_HZ/20 MHz) and the effective divider. A block longer than 64 bytes uses the effective divider alone. The effective divider is `fast_div`, with 0 treated as 1.
- R10: `done` pulses once at the end of each accepted, valid transaction. `rsp_last` is high with the final reply byte only.
- R11: After reset: chip select is high, SCLK is low, `req_ready` is high, and `par_ready` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| fast_div | input | DIV_W | Full-rate SCLK half-period in system clocks, latched at request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted |
| req_cmd | input | 8 | Command opcode |
| req_len | input | LEN_W | Parameter count for a write, reply length for a read |
| par_valid | input | 1 | Parameter byte present |
| par_ready | output | 1 | Engine takes a parameter byte |
| par_data | input | 8 | Parameter byte |
| rsp_valid | output | 1 | Reply byte pulse |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final reply byte |
| done | output | 1 | Transaction finished |
| err | output | 1 | Request rejected |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | Data/command select, high for parameters |

## Verification
The assertions assume three things. A request is held for only one cycle while `req_ready` is high. A parameter byte is offered only in answer to `par_ready`. `spi_miso` changes only after rising SCLK edges. The bench meets all three. It drives requests and parameters on falling system-clock edges, each for one cycle. It moves its MISO model on the rising serial-clock edge, so each reply bit is stable through the next sampling edge. It sweeps all 256 opcodes with a zero count. It times every SCLK pulse against half-periods it works out from the system frequency and the divider.

// File: rtl/dbi_pkg.sv
`timescale 1ns/1ps
package dbi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_CMD,
        ST_PAR_WAIT,
        ST_PAR_SHIFT,
        ST_RD_SHIFT,
        ST_DONE
    } eng_state_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_PAR,
        PH_RD
    } phase_e;

    localparam logic [7:0] OP_IDENT  = 8'h04;
    localparam logic [7:0] OP_STATUS = 8'h09;

    // R4: fixed set of read opcodes
    function automatic logic is_read_op(input logic [7:0] op);
        unique case (op)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
            8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
            8'h56, 8'h5F, 8'hA1, 8'hA8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // R7: queries that answer after one dummy clock
    function automatic logic needs_realign(input logic [7:0] op);
        return (op == OP_IDENT) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/dbi_rate_select.sv
`timescale 1ns/1ps
module dbi_rate_select
    import dbi_pkg::*;
#(
    parameter int SYS_HZ     = 250_000_000,
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 8,
    parameter int LONG_LIMIT = 64,
    parameter int HALF_W     = DIV_W + 1
) (
    input  phase_e              phase,
    input  logic [DIV_W-1:0]    fast_div,
    input  logic [LEN_W-1:0]    par_len,
    output logic [HALF_W-1:0]   half
);
    // R9 / R8: slow-phase half-periods rounded up so the rate never exceeds the cap
    localparam int CMD_HALF = (SYS_HZ + 19_999_999) / 20_000_000;
    localparam int RD_HALF  = (SYS_HZ + 3_999_999) / 4_000_000;

    logic [HALF_W-1:0] fd1;
    logic [HALF_W-1:0] fd2;
    logic [HALF_W-1:0] cmd_h;
    logic [HALF_W-1:0] rd_h;
    logic [HALF_W-1:0] capped;

    always_comb begin
        fd1    = (fast_div == '0) ? HALF_W'(1) : HALF_W'(fast_div);
        fd2    = fd1 << 1;
        cmd_h  = HALF_W'(CMD_HALF);
        rd_h   = HALF_W'(RD_HALF);
        capped = (cmd_h > fd1) ? cmd_h : fd1;
        unique case (phase)
            PH_CMD:  half = capped;
            PH_PAR:  half = (int'(par_len) > LONG_LIMIT) ? fd1 : capped;
            PH_RD:   half = (rd_h > fd2) ? rd_h : fd2;
            default: half = fd1;
        endcase
    end

endmodule

// File: rtl/dbi_byte_shifter.sv
`timescale 1ns/1ps
module dbi_byte_shifter
    import dbi_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        tx_byte,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rx_byte
);
    sh_state_e         st;
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] hcur;
    logic [2:0]        bitn;
    logic [7:0]        sreg;
    logic [7:0]        rreg;
    logic              half_end;

    assign half_end = (cnt == hcur - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= SH_IDLE;
            cnt  <= '0;
            hcur <= HALF_W'(1);
            bitn <= '0;
            sreg <= '0;
            rreg <= '0;
        end else begin
            unique case (st)
                SH_IDLE: begin
                    if (go) begin
                        st   <= SH_LOW;
                        sreg <= tx_byte;
                        hcur <= half;
                        cnt  <= '0;
                        bitn <= '0;
                    end
                end
                SH_LOW: begin
                    if (half_end) begin
                        st   <= SH_HIGH;
                        cnt  <= '0;
                        rreg <= {rreg[6:0], miso};
                    end else begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                SH_HIGH: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (bitn == 3'd7) begin
                            st <= SH_IDLE;
                        end else begin
                            st   <= SH_LOW;
                            bitn <= bitn + 3'd1;
                            sreg <= {sreg[6:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    always_comb begin
        sclk    = (st == SH_HIGH);
        mosi    = (st != SH_IDLE) && sreg[7];
        busy    = (st != SH_IDLE);
        done    = (st == SH_HIGH) && half_end && (bitn == 3'd7);
        rx_byte = rreg;
    end

    // R9: a byte never starts with a zero half-period
    a_r9_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (go && st == SH_IDLE) |-> (half != '0));

    // R5: mode 0, MOSI does not move while SCLK is high
    a_r5_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/dbi_cmd_fsm.sv
`timescale 1ns/1ps
module dbi_cmd_fsm
    import dbi_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] fast_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             par_valid,
    output logic             par_ready,
    input  logic [7:0]       par_data,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_last,
    output logic             done,
    output logic             err,
    output logic             cs_n,
    output logic             dc,
    output logic             sh_go,
    output logic [7:0]       sh_tx,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output phase_e           phase,
    output logic [DIV_W-1:0] lat_div,
    output logic [LEN_W-1:0] lat_len
);
    localparam int REM_W = LEN_W + 1;

    eng_state_e       st;
    eng_state_e       nxt;
    logic [7:0]       cmd_q;
    logic [7:0]       par_q;
    logic [7:0]       prev_q;
    logic             rd_q;
    logic             aln_q;
    logic             first_q;
    logic [REM_W-1:0] rem;
    logic             req_rd;
    logic             req_aln;
    logic             req_bad;
    logic             rem_one;

    always_comb begin
        req_rd  = is_read_op(req_cmd);
        req_aln = needs_realign(req_cmd);
        // R6: reject empty reads and mis-sized realigned queries
        req_bad = req_rd && ((req_len == '0) ||
                  (req_aln && !(req_len == LEN_W'(3) || req_len == LEN_W'(4))));
        rem_one = (rem == REM_W'(1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (req_valid) nxt = req_bad ? ST_REJECT : ST_CMD;
            ST_REJECT:    nxt = ST_IDLE;
            ST_CMD:       if (sh_done) nxt = rd_q ? ST_RD_SHIFT :
                                             (lat_len == '0) ? ST_DONE : ST_PAR_WAIT;
            ST_PAR_WAIT:  if (par_valid) nxt = ST_PAR_SHIFT;
            ST_PAR_SHIFT: if (sh_done) nxt = rem_one ? ST_DONE : ST_PAR_WAIT;
            ST_RD_SHIFT:  if (sh_done && rem_one) nxt = ST_DONE;
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (st == ST_IDLE);
        par_ready = (st == ST_PAR_WAIT);
        cs_n      = !((st == ST_CMD) || (st == ST_PAR_WAIT) ||
                      (st == ST_PAR_SHIFT) || (st == ST_RD_SHIFT));
        dc        = (st == ST_PAR_WAIT) || (st == ST_PAR_SHIFT);
        sh_go     = (st == ST_CMD) || (st == ST_PAR_SHIFT) || (st == ST_RD_SHIFT);
        sh_tx     = (st == ST_CMD) ? cmd_q : (st == ST_PAR_SHIFT) ? par_q : 8'h00;
        phase     = (st == ST_RD_SHIFT) ? PH_RD :
                    (st == ST_PAR_SHIFT) ? PH_PAR : PH_CMD;
        done      = (st == ST_DONE);
        err       = (st == ST_REJECT);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            par_q     <= '0;
            prev_q    <= '0;
            rd_q      <= 1'b0;
            aln_q     <= 1'b0;
            first_q   <= 1'b0;
            rem       <= '0;
            lat_div   <= '0;
            lat_len   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            if (st == ST_IDLE && req_valid && !req_bad) begin
                cmd_q   <= req_cmd;
                rd_q    <= req_rd;
                aln_q   <= req_rd && req_aln;
                first_q <= 1'b1;
                lat_div <= fast_div;
                lat_len <= req_len;
                rem     <= (req_rd && req_aln) ? ({1'b0, req_len} + REM_W'(1))
                                               : {1'b0, req_len};
            end
            if (st == ST_PAR_WAIT && par_valid) par_q <= par_data;
            if (sh_done && (st == ST_PAR_SHIFT || st == ST_RD_SHIFT))
                rem <= rem - REM_W'(1);
            if (sh_done && st == ST_RD_SHIFT) begin
                if (aln_q) begin
                    prev_q  <= sh_rx;
                    first_q <= 1'b0;
                    if (!first_q) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= {prev_q[6:0], sh_rx[7]};
                        rsp_last  <= rem_one;
                    end
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= sh_rx;
                    rsp_last  <= rem_one;
                end
            end
        end
    end

    // R10: final reply byte lines up with the end pulse
    a_r10_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |-> done);

    // R6: an error pulse only follows an accepted request
    a_r6_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid && req_ready));

endmodule

// File: rtl/dbi_spi_engine.sv
`timescale 1ns/1ps
module dbi_spi_engine
    import dbi_pkg::*;
#(
    parameter int SYS_HZ     = 250_000_000,
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 8,
    parameter int LONG_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] fast_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [LEN_W-1:0] req_len,
    input  logic             par_valid,
    output logic             par_ready,
    input  logic [7:0]       par_data,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_last,
    output logic             done,
    output logic             err,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             spi_dc
);
    localparam int HALF_W = DIV_W + 1;

    phase_e            phase;
    logic [DIV_W-1:0]  lat_div;
    logic [LEN_W-1:0]  lat_len;
    logic [HALF_W-1:0] half;
    logic              sh_go;
    logic [7:0]        sh_tx;
    logic              sh_busy;
    logic              sh_done;
    logic [7:0]        sh_rx;

    dbi_cmd_fsm #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fast_div(fast_div),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_len(req_len),
        .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .done(done), .err(err), .cs_n(spi_cs_n), .dc(spi_dc),
        .sh_go(sh_go), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
        .phase(phase), .lat_div(lat_div), .lat_len(lat_len)
    );

    dbi_rate_select #(
        .SYS_HZ(SYS_HZ), .DIV_W(DIV_W), .LEN_W(LEN_W),
        .LONG_LIMIT(LONG_LIMIT), .HALF_W(HALF_W)
    ) u_rate (
        .phase(phase), .fast_div(lat_div), .par_len(lat_len), .half(half)
    );

    dbi_byte_shifter #(.HALF_W(HALF_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx), .half(half),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx)
    );

    // R1: serial clock pulses only inside a selected transaction
    a_r1_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R2: D/C never moves in the middle of a byte
    a_r2_dc_stable_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && $past(sh_busy)) |-> $stable(spi_dc));

    // R3: parameters are requested only in the data phase of a selected link
    a_r3_par_ready_data: assert property (@(posedge clk) disable iff (!rst_n)
        par_ready |-> (spi_dc && !spi_cs_n));

    // R5: reply bytes come from a command-phase read
    a_r5_rsp_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!spi_cs_n && !spi_dc));

endmodule

// File: tb/dbi_spi_engine_bench.sv
`timescale 1ns/1ps
module dbi_spi_engine_bench;

    localparam int SYS_HZ = 250_000_000;
    localparam int CMD_H  = (SYS_HZ + 19_999_999) / 20_000_000;
    localparam int RD_H   = (SYS_HZ + 3_999_999) / 4_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fast_div = 8'd1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_cmd = 8'h00;
    logic [7:0] req_len = 8'h00;
    logic       par_valid = 1'b0;
    logic       par_ready;
    logic [7:0] par_data = 8'h00;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_last;
    logic       done;
    logic       err;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso;
    logic       spi_cs_n;
    logic       spi_dc;

    always #2 clk = ~clk;

    dbi_spi_engine #(.SYS_HZ(SYS_HZ)) u_dbi_spi_engine (
        .clk(clk), .rst_n(rst_n), .fast_div(fast_div),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_len(req_len),
        .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .done(done), .err(err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    int checks = 0;
    int errors = 0;

    // device model: reply bits advance on rising SCLK after the command byte
    logic [63:0] rbits = '0;
    int          mrise = 0;
    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) mrise <= 0;
        else          mrise <= mrise + 1;
    end
    assign spi_miso = (mrise >= 8 && mrise < 72) ? rbits[63 - (mrise - 8)] : 1'b0;

    // monitor, sampled on falling system-clock edges
    int   nbytes = 0, bitc = 0, hcnt = 0, cs_rises = 0, rcnt = 0;
    int   done_cnt = 0, err_cnt = 0;
    logic [7:0] mbyte = 0;
    logic [7:0] bytes_q [0:79];
    logic       dcs_q   [0:79];
    int         widths  [0:79];
    logic [7:0] rsp_b   [0:63];
    logic       rsp_l   [0:63];
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (!spi_cs_n && prev_cs) begin
            nbytes = 0;
            bitc = 0;
        end
        if (spi_cs_n && !prev_cs) cs_rises = cs_rises + 1;
        if (spi_sclk && !prev_sclk) begin
            mbyte = {mbyte[6:0], spi_mosi};
            bitc = bitc + 1;
            if (bitc == 8) begin
                if (nbytes < 80) begin
                    bytes_q[nbytes] = mbyte;
                    dcs_q[nbytes] = spi_dc;
                end
                nbytes = nbytes + 1;
                bitc = 0;
            end
            hcnt = 1;
        end else if (spi_sclk) begin
            hcnt = hcnt + 1;
        end
        if (!spi_sclk && prev_sclk) begin
            if (bitc == 0) begin
                if (nbytes >= 1 && nbytes <= 80) widths[nbytes-1] = hcnt;
            end else if (nbytes < 80) begin
                widths[nbytes] = hcnt;
            end
        end
        if (rsp_valid && rcnt < 64) begin
            rsp_b[rcnt] = rsp_data;
            rsp_l[rcnt] = rsp_last;
            rcnt = rcnt + 1;
        end
        if (done) done_cnt = done_cnt + 1;
        if (err)  err_cnt = err_cnt + 1;
        prev_sclk = spi_sclk;
        prev_cs = spi_cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_read(input int op);
        case (op)
            'h04, 'h06, 'h07, 'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E,
            'h0F, 'h2E, 'h3E, 'h45, 'h52, 'h54, 'h56, 'h5F, 'hA1, 'hA8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    logic [7:0] par_buf [0:79];
    int rbase, dbase, ebase, cbase;

    task automatic run_txn(input int op, input int n, input int fd);
        rbase = rcnt; dbase = done_cnt; ebase = err_cnt; cbase = cs_rises;
        @(negedge clk);
        req_cmd = op[7:0];
        req_len = n[7:0];
        fast_div = fd[7:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_read(op)) begin
            for (int i = 0; i < n; i++) begin
                while (!par_ready) @(negedge clk);
                par_data = par_buf[i];
                par_valid = 1'b1;
                @(negedge clk);
                par_valid = 1'b0;
            end
        end
        while (done_cnt == dbase && err_cnt == ebase) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_write(input int op, input int n, input int fd, input string tg);
        int fd1, ph;
        fd1 = (fd == 0) ? 1 : fd;
        ph = (n > 64) ? fd1 : maxi(CMD_H, fd1);
        chk(nbytes == n + 1, {tg, " R3 byte count"}, nbytes, n + 1);
        chk(bytes_q[0] == op[7:0] && dcs_q[0] == 1'b0, {tg, " R2 command byte dc low"},
            int'(bytes_q[0]), op);
        chk(widths[0] == maxi(CMD_H, fd1), {tg, " R9 command half-period"},
            widths[0], maxi(CMD_H, fd1));
        for (int i = 0; i < n; i++) begin
            chk(bytes_q[i+1] == par_buf[i] && dcs_q[i+1] == 1'b1,
                {tg, " R3 parameter byte dc high"}, int'(bytes_q[i+1]), int'(par_buf[i]));
            chk(widths[i+1] == ph, {tg, " R9 parameter half-period"}, widths[i+1], ph);
        end
        chk(cs_rises == cbase + 1, {tg, " R1 single chip-select window"}, cs_rises - cbase, 1);
        chk(done_cnt == dbase + 1, {tg, " R10 done pulse"}, done_cnt - dbase, 1);
    endtask

    task automatic check_read(input int op, input int n, input int fd, input bit aln,
                              input string tg);
        int fd1, nb, ex;
        logic [7:0] b0, b1;
        fd1 = (fd == 0) ? 1 : fd;
        nb = aln ? n + 1 : n;
        chk(nbytes == nb + 1, {tg, " R7 bytes clocked"}, nbytes, nb + 1);
        chk(widths[0] == maxi(CMD_H, fd1), {tg, " R9 command half-period"},
            widths[0], maxi(CMD_H, fd1));
        for (int i = 0; i < nb; i++) begin
            chk(dcs_q[i+1] == 1'b0 && bytes_q[i+1] == 8'h00, {tg, " R5 read phase dc low mosi 0"},
                int'(bytes_q[i+1]), 0);
            chk(widths[i+1] == maxi(RD_H, 2 * fd1), {tg, " R8 read half-period"},
                widths[i+1], maxi(RD_H, 2 * fd1));
        end
        chk(rcnt - rbase == n, {tg, " R5 reply count"}, rcnt - rbase, n);
        for (int i = 0; i < n; i++) begin
            b0 = rbits[63 - 8*i -: 8];
            b1 = rbits[63 - 8*(i+1) -: 8];
            ex = aln ? int'({b0[6:0], b1[7]}) : int'(b0);
            chk(int'(rsp_b[rbase+i]) == ex, {tg, aln ? " R7 realigned reply" : " R5 reply byte"},
                int'(rsp_b[rbase+i]), ex);
            chk(rsp_l[rbase+i] == (i == n - 1), {tg, " R10 rsp_last"},
                int'(rsp_l[rbase+i]), int'(i == n - 1));
        end
        chk(cs_rises == cbase + 1, {tg, " R1 single chip-select window"}, cs_rises - cbase, 1);
        chk(done_cnt == dbase + 1, {tg, " R10 done pulse"}, done_cnt - dbase, 1);
    endtask

    task automatic check_reject(input int op, input int n, input string tg);
        run_txn(op, n, 1);
        chk(err_cnt == ebase + 1, {tg, " R6 err pulse"}, err_cnt - ebase, 1);
        chk(cs_rises == cbase && done_cnt == dbase, {tg, " R6 no chip select"},
            cs_rises - cbase, 0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R11 idle link", int'(spi_cs_n), 1);
        chk(req_ready && !par_ready && !rsp_valid, "R11 idle handshakes", int'(req_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);

        // window command, short block
        par_buf[0] = 8'h00; par_buf[1] = 8'h10; par_buf[2] = 8'h00; par_buf[3] = 8'h7F;
        run_txn('h2A, 4, 2);
        check_write('h2A, 4, 2, "win2A");

        run_txn('h29, 0, 2);
        check_write('h29, 0, 2, "zero");

        for (int i = 0; i < 80; i++) par_buf[i] = 8'(i * 7 + 3);
        run_txn('h2C, 64, 2);
        check_write('h2C, 64, 2, "blk64");
        run_txn('h2C, 65, 2);
        check_write('h2C, 65, 2, "blk65");
        run_txn('h2B, 2, 20);
        check_write('h2B, 2, 20, "slowdiv");
        run_txn('h2C, 66, 0);
        check_write('h2C, 66, 0, "div0");

        // plain reads
        rbits = 64'h9C5A_0000_0000_0000;
        run_txn('h0A, 1, 1);
        check_read('h0A, 1, 1, 1'b0, "pmode");
        run_txn('h0A, 1, 40);
        check_read('h0A, 1, 40, 1'b0, "pmode_slow");
        rbits = 64'hE1_3C_77_00_0000_0000;
        run_txn('h2E, 2, 3);
        check_read('h2E, 2, 3, 1'b0, "memrd");

        // dummy-clock reads
        rbits = 64'hA5_3C_F1_80_00_00_00_00;
        run_txn('h04, 3, 1);
        check_read('h04, 3, 1, 1'b1, "ident");
        rbits = 64'h7F_01_C3_99_FF_00_00_00;
        run_txn('h09, 4, 1);
        check_read('h09, 4, 1, 1'b1, "status");

        // rejects
        check_reject('h04, 2, "ident_len2");
        check_reject('h09, 5, "status_len5");
        check_reject('h0A, 0, "read_len0");
        check_reject('h04, 0, "ident_len0");

        // R4: classification sweep with a zero count
        for (int op = 0; op < 256; op++) begin
            run_txn(op, 0, 1);
            if (exp_read(op))
                chk(err_cnt == ebase + 1 && cs_rises == cbase, "R4 read opcode rejected at zero count",
                    op, 1);
            else
                chk(done_cnt == dbase + 1 && nbytes == 1 && bytes_q[0] == op[7:0],
                    "R4 write opcode sent alone", op, int'(bytes_q[0]));
        end

        summary();
        $finish;
    end

endmodule